// File: doc/BRIEF.md
# Multiple-Register Memory Transfer Sequencer

This block moves a contiguous run of general registers between a 16-entry register file and memory, one register per memory beat. A caller gives it a first and a last register index, a base register field together with that register's current value, a displacement, a direction (load from memory or store to memory) and an element size. When the last index is numerically below the first, the run wraps from register 15 back to register 0.

In wide mode each element is a full 64-bit register and consecutive elements are 8 bytes apart. In narrow mode each element is the low 32 bits of a register, elements are 4 bytes apart, and loads leave the upper half of each register as it was. The sequencer keeps exactly one memory request in flight, waits for its acknowledge, and then moves to the next register. A single-cycle done pulse follows the final acknowledge, and start pulses seen while it is busy are ignored.

Top module: `mreg_xfer`

## Requirements
- R1: The number of memory requests per operation equals ((last_idx − first_idx) mod 16) + 1; equal indices give exactly one request and last_idx = first_idx − 1 gives sixteen.
- R2: Element i uses register index (first_idx + i) mod 16, so indices rise by one per element and wrap from 15 to 0.
- R3: The address of element i is base + disp + stride × i, modulo 2^32, where stride is 8 bytes in wide mode (half = 0) and 4 bytes in narrow mode (half = 1).
- R4: When base_fld is 0 the base term is zero whatever base_val holds; for any other base_fld the base term is base_val.
- R5: On a load (store = 0), rf_we is high only in a cycle in which mem_ack is high, with rf_widx set to the element's register and rf_wdata carrying mem_rdata; rf_wbe is 2'b11 in wide mode and 2'b01 in narrow mode (bit 0 enables bits 31:0, bit 1 enables bits 63:32), so narrow loads leave bits 63:32 unchanged.
- R6: On a store (store = 1), each request has mem_we = 1 and mem_wdata equal to the register's 64-bit value in wide mode or {32'b0, its low 32 bits} in narrow mode; mem_half equals the operation's half setting on every request; rf_we stays low.
- R7: mem_req is high for exactly one cycle per element; no further request is issued until the cycle after the acknowledge of the previous one, and the next request follows that acknowledge by exactly one cycle.
- R8: busy rises in the cycle after an accepted start and falls in the cycle after the final acknowledge; done is high for exactly that one cycle.
- R9: A start pulse while busy is high has no effect: the running operation keeps its own fields and no extra request follows its done.
- R10: After reset busy, done, mem_req and rf_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| store | input | 1 | 1 = registers to memory, 0 = memory to registers |
| half | input | 1 | 1 = 32-bit elements with 4-byte stride, 0 = 64-bit elements with 8-byte stride |
| first_idx | input | 4 | First register of the run |
| last_idx | input | 4 | Last register of the run |
| base_fld | input | 4 | Base register field; 0 selects a zero base |
| base_val | input | 32 | Contents of the base register |
| disp | input | 32 | Displacement added to the base |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_half | output | 1 | Request is 4 bytes (1) or 8 bytes (0) |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 64 | Read data |
| rf_ridx | output | 4 | Register file read index |
| rf_rdata | input | 64 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write strobe |
| rf_widx | output | 4 | Register file write index |
| rf_wdata | output | 64 | Register file write data |
| rf_wbe | output | 2 | Half-word write enables |

## Verification
The bench sweeps every pair of first and last indices in both directions and both sizes, so the wrapping ranges (last below first, and last one below first for a full sixteen-register run) are covered; a design that counted without the modulo would issue a wrong number of requests or stop early, and one that did not wrap the index would address register 16. Base field zero is paired with a nonzero base value, so a design that added the value anyway shows a shifted address, and displacements near the top of the address space check the address wrap. Narrow loads start from registers with distinctive upper halves, so a design that wrote all 64 bits would corrupt them in the final register-file comparison. Acknowledge latency varies, and start pulses are injected mid-operation; a design that re-latched fields or issued requests early would show stray or misplaced requests.

// File: rtl/mreg_xfer_pkg.sv
package mreg_xfer_pkg;

    localparam int RIDX_W = 4;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_WAIT = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic store;
        logic half;
    } xfer_mode_t;

    function automatic logic [RIDX_W-1:0] span_minus_one(
        input logic [RIDX_W-1:0] first,
        input logic [RIDX_W-1:0] last
    );
        return last - first;
    endfunction

endpackage

// File: rtl/mreg_xfer_walk.sv
module mreg_xfer_walk
    import mreg_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [RIDX_W-1:0] first,
    input  logic [RIDX_W-1:0] last,
    output logic [RIDX_W-1:0] idx,
    output logic              final_elem
);

    logic [RIDX_W-1:0] idx_q;
    logic [RIDX_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            left_q <= '0;
        end else if (load) begin
            idx_q  <= first;
            left_q <= span_minus_one(first, last);
        end else if (advance) begin
            idx_q  <= idx_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    assign idx        = idx_q;
    assign final_elem = (left_q == '0);

    // R1: never stepped past the end of the run
    p_no_overrun_r1: assert property (@(posedge clk) disable iff (rst)
        advance |-> !final_elem);

    // R2: index moves up by one modulo 16 on each step
    p_idx_step_r2: assert property (@(posedge clk) disable iff (rst)
        (advance && !load) |=> idx == $past(idx) + 1'b1);

endmodule

// File: rtl/mreg_xfer_agen.sv
module mreg_xfer_agen
    import mreg_xfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic              half,
    input  logic [RIDX_W-1:0] base_fld,
    input  logic [AW-1:0]     base_val,
    input  logic [AW-1:0]     disp,
    output logic [AW-1:0]     addr
);

    localparam int WIDE_STRIDE   = DW / 8;
    localparam int NARROW_STRIDE = DW / 16;
    localparam logic [AW-1:0] WIDE_STEP   = AW'(WIDE_STRIDE);
    localparam logic [AW-1:0] NARROW_STEP = AW'(NARROW_STRIDE);

    logic [AW-1:0] addr_q;
    logic          half_q;
    logic [AW-1:0] base_term;
    logic [AW-1:0] step;

    assign base_term = (base_fld == '0) ? '0 : base_val;
    assign step      = half_q ? NARROW_STEP : WIDE_STEP;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            half_q <= 1'b0;
        end else if (load) begin
            addr_q <= base_term + disp;
            half_q <= half;
        end else if (advance) begin
            addr_q <= addr_q + step;
        end
    end

    assign addr = addr_q;

    // R3: consecutive elements are one stride apart
    p_stride_r3: assert property (@(posedge clk) disable iff (rst)
        (advance && !load) |=> (addr - $past(addr)) == (half_q ? NARROW_STEP : WIDE_STEP));

endmodule

// File: rtl/mreg_xfer.sv
module mreg_xfer
    import mreg_xfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              store,
    input  logic              half,
    input  logic [RIDX_W-1:0] first_idx,
    input  logic [RIDX_W-1:0] last_idx,
    input  logic [RIDX_W-1:0] base_fld,
    input  logic [AW-1:0]     base_val,
    input  logic [AW-1:0]     disp,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_half,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic [RIDX_W-1:0] rf_ridx,
    input  logic [DW-1:0]     rf_rdata,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_widx,
    output logic [DW-1:0]     rf_wdata,
    output logic [1:0]        rf_wbe
);

    localparam int HW = DW / 2;

    sq_state_e         state_q, state_d;
    xfer_mode_t        mode_q;
    logic              done_q;
    logic              accept;
    logic              beat_end;
    logic              step;
    logic              final_elem;
    logic [RIDX_W-1:0] idx;

    assign accept   = start && (state_q == SQ_IDLE);
    assign beat_end = (state_q == SQ_WAIT) && mem_ack;
    assign step     = beat_end && !final_elem;

    mreg_xfer_walk u_walk (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .advance    (step),
        .first      (first_idx),
        .last       (last_idx),
        .idx        (idx),
        .final_elem (final_elem)
    );

    mreg_xfer_agen #(.AW(AW), .DW(DW)) u_agen (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .advance  (step),
        .half     (half),
        .base_fld (base_fld),
        .base_val (base_val),
        .disp     (disp),
        .addr     (mem_addr)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: if (accept) state_d = SQ_REQ;
            SQ_REQ:  state_d = SQ_WAIT;
            SQ_WAIT: if (mem_ack) state_d = final_elem ? SQ_IDLE : SQ_REQ;
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            mode_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= beat_end && final_elem;
            if (accept) begin
                mode_q.store <= store;
                mode_q.half  <= half;
            end
        end
    end

    assign busy     = (state_q != SQ_IDLE);
    assign done     = done_q;
    assign mem_req  = (state_q == SQ_REQ);
    assign mem_we   = mode_q.store;
    assign mem_half = mode_q.half;

    assign rf_ridx   = idx;
    assign mem_wdata = mode_q.half ? {{HW{1'b0}}, rf_rdata[HW-1:0]} : rf_rdata;

    assign rf_we    = beat_end && !mode_q.store;
    assign rf_widx  = idx;
    assign rf_wdata = mode_q.half ? {{HW{1'b0}}, mem_rdata[HW-1:0]} : mem_rdata;
    assign rf_wbe   = mode_q.half ? 2'b01 : 2'b11;

    // R7: a request is never followed directly by another request
    p_single_req_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R8: done lasts one cycle and follows an acknowledge
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(mem_ack) && !busy));

    // R5: register writes only on an acknowledge of a load
    p_load_write_r5: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (mem_ack && !mem_we && busy));
    p_half_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (rf_we && mem_half) |-> (rf_wbe == 2'b01));

    // R9: a start while busy does not end the operation early
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !mem_ack) |=> busy);

    // R10: quiet outputs right after reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !mem_req));

endmodule

// File: tb/mreg_xfer_bench.sv
module mreg_xfer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int MEM_BYTES = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          store = 1'b0;
    logic          half = 1'b0;
    logic [3:0]    first_idx = '0;
    logic [3:0]    last_idx = '0;
    logic [3:0]    base_fld = '0;
    logic [AW-1:0] base_val = '0;
    logic [AW-1:0] disp = '0;
    logic          busy, done, mem_req, mem_we, mem_half;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic [3:0]    rf_ridx;
    logic [DW-1:0] rf_rdata;
    logic          rf_we;
    logic [3:0]    rf_widx;
    logic [DW-1:0] rf_wdata;
    logic [1:0]    rf_wbe;

    logic [DW-1:0] rf_model [16];
    logic [7:0]    bmem [MEM_BYTES];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign rf_rdata = rf_model[rf_ridx];

    mreg_xfer u_mreg_xfer (
        .clk(clk), .rst(rst), .start(start), .store(store), .half(half),
        .first_idx(first_idx), .last_idx(last_idx), .base_fld(base_fld),
        .base_val(base_val), .disp(disp), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .rf_ridx(rf_ridx), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata), .rf_wbe(rf_wbe)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_rd(input logic [AW-1:0] a, input bit h);
        logic [63:0] v = '0;
        for (int k = 0; k < 8; k++)
            if (!h || k < 4) v[k*8 +: 8] = bmem[(a + AW'(k)) % MEM_BYTES];
        return v;
    endfunction

    task automatic init_rf(input int seed);
        for (int r = 0; r < 16; r++)
            rf_model[r] = {32'hC000_0000 + 32'(seed) * 32'h100 + 32'(r),
                           32'h1111_0000 + 32'(seed) * 32'h20 + 32'(r)};
    endtask

    task automatic run_op(input bit st, input bit h, input int fi, input int la,
                          input int bf, input logic [AW-1:0] bv, input logic [AW-1:0] dp,
                          input int lat, input bit inject, input int seed);
        logic [63:0]   exp_rf [16];
        logic [AW-1:0] org;
        logic [AW-1:0] ea;
        logic [63:0]   ed;
        int n;
        int r;
        init_rf(seed);
        for (int k = 0; k < 16; k++) exp_rf[k] = rf_model[k];
        n   = ((la - fi) & 15) + 1;
        org = ((bf == 0) ? '0 : bv) + dp;
        if (!st)
            for (int e = 0; e < n; e++) begin
                r  = (fi + e) & 15;
                ed = mem_rd(org + AW'(e * (h ? 4 : 8)), h);
                if (h) exp_rf[r][31:0] = ed[31:0];
                else   exp_rf[r] = ed;
            end
        @(negedge clk);
        start = 1'b1; store = st; half = h;
        first_idx = 4'(fi); last_idx = 4'(la); base_fld = 4'(bf);
        base_val = bv; disp = dp;
        @(negedge clk);
        start = 1'b0;
        for (int e = 0; e < n; e++) begin
            r  = (fi + e) & 15;
            ea = org + AW'(e * (h ? 4 : 8));
            chk(mem_req === 1'b1, "R1 R7 request expected", 64'(mem_req), 64'd1);
            chk(busy === 1'b1, "R8 busy during op", 64'(busy), 64'd1);
            chk(mem_addr === ea, "R3 R4 address", 64'(mem_addr), 64'(ea));
            chk(rf_ridx === 4'(r), "R2 register order", 64'(rf_ridx), 64'(r));
            chk(mem_we === st, "R6 direction", 64'(mem_we), 64'(st));
            chk(mem_half === h, "R6 size", 64'(mem_half), 64'(h));
            if (st) begin
                ed = h ? {32'b0, exp_rf[r][31:0]} : exp_rf[r];
                chk(mem_wdata === ed, "R6 store data", mem_wdata, ed);
            end
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                start = 1'b0;
                chk(mem_req === 1'b0, "R7 single outstanding", 64'(mem_req), 64'd0);
                if (inject && e == 0 && i == 0) begin
                    start = 1'b1; store = ~st; half = ~h;
                    first_idx = 4'(fi + 5); last_idx = 4'(fi + 5);
                    disp = dp + 32'h40;
                end
            end
            mem_ack = 1'b1;
            mem_rdata = mem_rd(mem_addr, h) | (h ? 64'hDEAD_0000_0000_0000 : 64'h0);
            #1;
            if (st) begin
                chk(rf_we === 1'b0, "R6 no register write on store", 64'(rf_we), 64'd0);
                for (int k = 0; k < (h ? 4 : 8); k++)
                    bmem[(mem_addr + AW'(k)) % MEM_BYTES] = mem_wdata[k*8 +: 8];
            end else begin
                chk(rf_we === 1'b1, "R5 write on ack", 64'(rf_we), 64'd1);
                chk(rf_widx === 4'(r), "R5 R2 write index", 64'(rf_widx), 64'(r));
                chk(rf_wbe === (h ? 2'b01 : 2'b11), "R5 write enables", 64'(rf_wbe), h ? 64'd1 : 64'd3);
                if (rf_wbe[0]) rf_model[rf_widx][31:0]  = rf_wdata[31:0];
                if (rf_wbe[1]) rf_model[rf_widx][63:32] = rf_wdata[63:32];
            end
            @(negedge clk);
            start = 1'b0;
            mem_ack = 1'b0;
        end
        chk(done === 1'b1, "R8 done after final ack", 64'(done), 64'd1);
        chk(busy === 1'b0, "R8 busy drops", 64'(busy), 64'd0);
        chk(mem_req === 1'b0, "R1 no extra request", 64'(mem_req), 64'd0);
        @(negedge clk);
        chk(done === 1'b0, "R8 done one cycle", 64'(done), 64'd0);
        chk(mem_req === 1'b0 && busy === 1'b0, "R9 stray start ignored", 64'(busy), 64'd0);
        if (!st)
            for (int k = 0; k < 16; k++)
                chk(rf_model[k] === exp_rf[k], "R5 register file contents", rf_model[k], exp_rf[k]);
    endtask

    initial begin
        for (int a = 0; a < MEM_BYTES; a++) bmem[a] = 8'(a * 37 + 5);
        init_rf(0);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R10 reset idle", {busy, done}, 64'd0);
        chk(mem_req === 1'b0 && rf_we === 1'b0, "R10 reset quiet", {mem_req, rf_we}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && mem_req === 1'b0, "R10 idle after reset", {busy, mem_req}, 64'd0);
        begin
            int op = 0;
            for (int h = 0; h < 2; h++)
                for (int st = 0; st < 2; st++)
                    for (int fi = 0; fi < 16; fi++)
                        for (int la = 0; la < 16; la++) begin
                            logic [AW-1:0] dp;
                            op++;
                            dp = (op % 7 == 0) ? 32'hFFFF_FFC0 : 32'((op * 4) % 512);
                            run_op(st[0], h[0], fi, la, (fi + la + st) % 4,
                                   32'h0000_0200 + 32'(op * 8), dp,
                                   1 + (fi + la) % 3, (op % 5) == 0, op);
                        end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule